// File: doc/BRIEF.md
# Write-Completing Chip-Enable Gate

This block sits in the active-low chip-enable path of a battery-backed static memory and stops the memory from being selected while the supply supervisor holds the system in reset. When there is no fault, the incoming chip-enable reaches the memory through a purely combinational path, so no clock latency is added. When the supervisor reset rises, the gate closes, and the closed gate drives the memory select to its inactive high level whatever the processor side is doing.

Closing depends on the bus state at the moment the fault is seen. With no access in flight, the gate shuts at once. If a select is already low, the gate stays transparent until that select returns high or until a bounded drain window expires, so a write that has already started is not cut off part way. After the supervisor reset drops, the gate stays shut for a fixed settle window before it opens again. Both windows are counted in pulses of a shared timebase strobe (`tick`), so the same RTL serves any clock rate.

Top module: `ce_write_guard`

## Requirements
- R1: While the gate is open and no fault has been seen, `ce_out_n` equals `ce_in_n` in the same cycle, with no register in between.
- R2: At a clock edge where `sup_rst` is high, the gate is open in its normal state and `ce_in_n` is high, the gate closes: from that edge on, `gate_open` is 0.
- R3: At a clock edge where `sup_rst` is high, the gate is open in its normal state and `ce_in_n` is low, the gate enters draining: `gate_open` stays 1 and `ce_out_n` keeps following `ce_in_n`.
- R4: While draining, the gate closes at the first clock edge at which `ce_in_n` is high.
- R5: While draining, the gate closes at the clock edge that samples the DRAIN_TICKS-th `tick` pulse counted since draining began, even if `ce_in_n` stays low.
- R6: While the gate is closed (`gate_open` = 0), `ce_out_n` is 1 for any value of `ce_in_n`.
- R7: A closed gate opens at the clock edge that samples the REOPEN_TICKS-th `tick` pulse seen with `sup_rst` low; any edge with `sup_rst` high sets this count back to zero.
- R8: If `sup_rst` falls while draining, the gate returns to normal pass-through at the next clock edge, without the settle window.
- R9: After `rst_n` is released, the gate is open in its normal state: `gate_open` = 1 and `ce_out_n` follows `ce_in_n`.
- R10: `gate_open` is 1 in the normal and draining states and 0 only while closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control logic |
| sup_rst | input | 1 | Supervisor reset state, 1 = supply fault / reset asserted |
| tick | input | 1 | One-cycle timebase strobe counted by both windows |
| ce_in_n | input | 1 | Incoming active-low chip-enable from the processor |
| ce_out_n | output | 1 | Gated active-low chip-enable to the memory |
| gate_open | output | 1 | 1 while the gate passes the chip-enable (normal or draining) |

## Verification
A wrong control state shows at the ports in the same cycle: a gate stuck closed turns a low `ce_in_n` into a high `ce_out_n`, and a gate stuck open passes a low select through while `gate_open` should be 0. A wrong window count shows as `gate_open` changing one or more tick pulses early or late, so every window test checks the count one pulse short of the limit and again exactly at it. The drain path is checked both ways, with the select ending on its own and with the select held low until the window expires, and the release and restart cases confirm that the settle count depends only on ticks seen with the fault gone.

// File: rtl/cegate_pkg.sv
package cegate_pkg;

   // Control states of the chip-enable gate
   typedef enum logic [1:0] {
      GATE_ON    = 2'd0,   // transparent, no fault
      GATE_DRAIN = 2'd1,   // fault seen, access in flight allowed to end
      GATE_OFF   = 2'd2    // closed, select forced inactive
   } gate_state_e;

   // Width of a counter that must reach limit-1
   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction

endpackage

// File: rtl/cegate_timer.sv
module cegate_timer #(
   parameter int unsigned LIMIT = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic expire
);
   import cegate_pkg::*;

   localparam int unsigned CW = cnt_width(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("cegate_timer: LIMIT must be at least 1");
      end
   endgenerate

   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   assign expire = run && tick && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= expire ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/cegate_ctrl.sv
module cegate_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_rst,
   input  logic ce_in_n,
   input  logic drain_exp,
   input  logic reopen_exp,
   output logic drain_run,
   output logic reopen_run,
   output logic pass_en
);
   import cegate_pkg::*;

   gate_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         GATE_ON: begin
            if (sup_rst) state_d = ce_in_n ? GATE_OFF : GATE_DRAIN;
         end
         GATE_DRAIN: begin
            if (!sup_rst)                  state_d = GATE_ON;
            else if (ce_in_n || drain_exp) state_d = GATE_OFF;
         end
         GATE_OFF: begin
            if (reopen_exp) state_d = GATE_ON;
         end
         default: state_d = GATE_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= GATE_ON;
      else        state_q <= state_d;
   end

   assign drain_run  = (state_q == GATE_DRAIN);
   assign reopen_run = (state_q == GATE_OFF) && !sup_rst;
   assign pass_en    = (state_q != GATE_OFF);

endmodule

// File: rtl/ce_write_guard.sv
module ce_write_guard #(
   parameter int unsigned DRAIN_TICKS  = 15,
   parameter int unsigned REOPEN_TICKS = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_rst,
   input  logic tick,
   input  logic ce_in_n,
   output logic ce_out_n,
   output logic gate_open
);

   generate
      if (DRAIN_TICKS < 1) begin : g_bad_drain
         $error("ce_write_guard: DRAIN_TICKS must be at least 1");
      end
      if (REOPEN_TICKS < 1) begin : g_bad_reopen
         $error("ce_write_guard: REOPEN_TICKS must be at least 1");
      end
   endgenerate

   logic drain_run, reopen_run;
   logic drain_exp, reopen_exp;
   logic pass_en;

   cegate_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sup_rst    (sup_rst),
      .ce_in_n    (ce_in_n),
      .drain_exp  (drain_exp),
      .reopen_exp (reopen_exp),
      .drain_run  (drain_run),
      .reopen_run (reopen_run),
      .pass_en    (pass_en)
   );

   cegate_timer #(.LIMIT(DRAIN_TICKS)) u_drain_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (drain_run),
      .tick   (tick),
      .expire (drain_exp)
   );

   cegate_timer #(.LIMIT(REOPEN_TICKS)) u_reopen_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (reopen_run),
      .tick   (tick),
      .expire (reopen_exp)
   );

   // Combinational pass path: no clock latency while open
   assign ce_out_n  = pass_en ? ce_in_n : 1'b1;
   assign gate_open = pass_en;

endmodule

// File: rtl/ce_write_guard_chk.sv
module ce_write_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic sup_rst,
   input logic tick,
   input logic ce_in_n,
   input logic ce_out_n,
   input logic gate_open
);

   // R1 / R3: an open gate is transparent
   p_pass_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
      gate_open |-> (ce_out_n == ce_in_n));

   // R6: a closed gate holds the select inactive
   p_closed_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_open |-> ce_out_n);

   // R2 / R4: fault with idle select closes the gate at that edge
   p_idle_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_open && sup_rst && ce_in_n) |=> !gate_open);

   // R3: fault with select low and no tick keeps the gate open
   p_drain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_open && sup_rst && !ce_in_n && !tick) |=> gate_open);

   // R7: no reopening while the fault persists
   p_stay_shut_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_open && sup_rst) |=> !gate_open);

   // R8: with the fault gone an open gate stays open
   p_release_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_open && !sup_rst) |=> gate_open);

   // R7: reopening only on a counted tick with the fault gone
   p_reopen_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_open && !(tick && !sup_rst)) |=> !gate_open);

endmodule

bind ce_write_guard ce_write_guard_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sup_rst   (sup_rst),
   .tick      (tick),
   .ce_in_n   (ce_in_n),
   .ce_out_n  (ce_out_n),
   .gate_open (gate_open)
);

// File: tb/sim_ce_write_guard.sv
module sim_ce_write_guard;

   localparam int CLK_PERIOD = 10;
   localparam int DRAIN_T    = 6;
   localparam int REOPEN_T   = 4;

   logic clk = 1'b0;
   logic rst_n, sup_rst, tick, ce_in_n;
   logic ce_out_n, gate_open;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ce_write_guard #(.DRAIN_TICKS(DRAIN_T), .REOPEN_TICKS(REOPEN_T)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .sup_rst   (sup_rst),
      .tick      (tick),
      .ce_in_n   (ce_in_n),
      .ce_out_n  (ce_out_n),
      .gate_open (gate_open)
   );

   task automatic chk(input logic act, input logic exp, input string tag, input string what);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("[TB] FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   // n tick pulses, each seen by exactly one rising edge
   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
      #1;
   endtask

   task automatic edge_step();
      @(negedge clk);
      #1;
   endtask

   task automatic t_reset();
      chk(gate_open, 1'b1, "R9", "gate open after reset");
      chk(ce_out_n, 1'b1, "R9", "idle select after reset");
      ce_in_n = 1'b0; #1;
      chk(ce_out_n, 1'b0, "R9", "select follows after reset");
      ce_in_n = 1'b1; #1;
   endtask

   task automatic t_pass();
      for (int i = 0; i < 4; i++) begin
         ce_in_n = i[0]; #1;
         chk(ce_out_n, i[0], "R1", "same-cycle pass");
         edge_step();
         chk(ce_out_n, i[0], "R1", "pass across edge");
      end
      ce_in_n = 1'b1; #1;
   endtask

   task automatic t_idle_close();
      sup_rst = 1'b1; ce_in_n = 1'b1;
      edge_step();
      chk(gate_open, 1'b0, "R2", "closed at fault edge");
      chk(gate_open, 1'b0, "R10", "status low when closed");
      ce_in_n = 1'b0; #1;
      chk(ce_out_n, 1'b1, "R6", "select forced high");
      edge_step();
      chk(ce_out_n, 1'b1, "R6", "select still high");
      ce_in_n = 1'b1; #1;
   endtask

   task automatic t_reopen();
      sup_rst = 1'b0;
      pulse(REOPEN_T - 1);
      chk(gate_open, 1'b0, "R7", "shut one tick short");
      pulse(1);
      chk(gate_open, 1'b1, "R7", "open at last tick");
   endtask

   task automatic t_restart();
      sup_rst = 1'b1; ce_in_n = 1'b1;
      edge_step();
      sup_rst = 1'b0;
      pulse(REOPEN_T - 1);
      sup_rst = 1'b1;
      edge_step();
      sup_rst = 1'b0;
      pulse(REOPEN_T - 1);
      chk(gate_open, 1'b0, "R7", "count restarted by fault");
      pulse(1);
      chk(gate_open, 1'b1, "R7", "open after full count");
   endtask

   task automatic t_drain_end();
      ce_in_n = 1'b0; sup_rst = 1'b1;
      edge_step();
      chk(gate_open, 1'b1, "R3", "draining keeps gate open");
      chk(ce_out_n, 1'b0, "R3", "write still selected");
      pulse(DRAIN_T - 1);
      chk(gate_open, 1'b1, "R3", "open one tick short");
      chk(gate_open, 1'b1, "R10", "status high while draining");
      ce_in_n = 1'b1; #1;
      chk(ce_out_n, 1'b1, "R4", "write end passes");
      edge_step();
      chk(gate_open, 1'b0, "R4", "closed after write end");
      ce_in_n = 1'b0; #1;
      chk(ce_out_n, 1'b1, "R6", "new select blocked");
      ce_in_n = 1'b1; sup_rst = 1'b0;
      pulse(REOPEN_T);
      chk(gate_open, 1'b1, "R7", "reopen after drain end");
   endtask

   task automatic t_drain_timeout();
      ce_in_n = 1'b0; sup_rst = 1'b1;
      edge_step();
      pulse(DRAIN_T - 1);
      chk(gate_open, 1'b1, "R5", "open before timeout");
      chk(ce_out_n, 1'b0, "R5", "select low before timeout");
      pulse(1);
      chk(gate_open, 1'b0, "R5", "closed at timeout");
      chk(ce_out_n, 1'b1, "R5", "select forced high at timeout");
      ce_in_n = 1'b1; sup_rst = 1'b0;
      pulse(REOPEN_T);
   endtask

   task automatic t_release();
      ce_in_n = 1'b0; sup_rst = 1'b1;
      edge_step();
      chk(gate_open, 1'b1, "R8", "draining before release");
      sup_rst = 1'b0;
      edge_step();
      pulse(DRAIN_T + 1);
      chk(gate_open, 1'b1, "R8", "normal after release");
      ce_in_n = 1'b1; #1;
      chk(ce_out_n, 1'b1, "R8", "pass high after release");
      sup_rst = 1'b1;
      edge_step();
      chk(gate_open, 1'b0, "R8", "normal state closes at once");
      sup_rst = 1'b0;
      pulse(REOPEN_T);
   endtask

   initial begin
      rst_n = 1'b0; sup_rst = 1'b0; tick = 1'b0; ce_in_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      edge_step();
      t_reset();
      t_pass();
      t_idle_close();
      t_reopen();
      t_restart();
      t_drain_end();
      t_drain_timeout();
      t_release();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("[TB] FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule